// File: doc/BRIEF.md
# CCD Electronic Shutter Pulse Controller

This block drives the substrate-clear pulse that sets a CCD's exposure time. It works from the pixel position within the current line, a line strobe, a field strobe and a flag that marks the sensor-gate line. In each field it emits one shutter pulse per line for a programmed number of lines. The train starts on the line after the sensor-gate line. Each pulse has a programmable window and polarity. An optional second window in the last line of the train gives finer control of the exposure. For exposures longer than one field, a field counter holds the shutter output idle for a programmed number of fields. During that time it also tells the sensor-gate generator to drop its pulses. It can also suppress the vertical and horizontal sync outputs.

Software writes the settings through a small write port into staging registers. The pulse window, polarity and pulse count move into use when the line strobe closes the sensor-gate line. The fine-pulse window, the exposure value and the sync-off bit take effect at the field strobe.

Top module: `shut_ctrl`

## Requirements
- R1: After the line strobe that ends a line with `gate_line` high, the next N lines each carry one shutter pulse, where N is the count staged at register address 3. Each further line strobe uses up one line.
- R2: In a pulse line, `sub_out` equals polarity XOR (t1a <= pixel < t1b). The polarity is bit 0 of address 0, t1a is address 1 and t1b is address 2. The output is registered, so it follows the pixel count one clock later. Outside pulse lines `sub_out` equals the polarity.
- R3: Writes to addresses 0 to 3 change nothing until the next line strobe that ends a gate line. A write made while a train is running does not alter that train.
- R4: A staged count of 0 gives no pulse in that field.
- R5: In the last line of a train, a second window (t2a <= pixel < t2b) is also pulsed. t2a is address 4 and t2b is address 5, and both take effect at the field strobe.
- R6: When t2a and t2b are both 4095, the second window is off. This is the reset value.
- R7: The exposure value at address 6 is loaded at a field strobe when the field counter is zero. At later field strobes the counter steps down by one. While the counter is nonzero, `sub_out` is held at the polarity value.
- R8: `gate_en` is low exactly while the field counter is nonzero.
- R9: With sync-off (bit 0 of address 7, taken at the field strobe) set, `sync_en` is low while the field counter is nonzero. Otherwise `sync_en` is high.
- R10: After reset, `sub_out` is 0, `gate_en` is 1 and `sync_en` is 1.
- R11: A field strobe ends any running train. If a field strobe and a gate-line-ending line strobe arrive together, the field strobe wins and no train starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix | input | 12 | Pixel position within the current line |
| line_stb | input | 1 | One-cycle strobe at the end of each line |
| field_stb | input | 1 | One-cycle strobe at the end of each field |
| gate_line | input | 1 | High during the sensor-gate line |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| sub_out | output | 1 | Shutter (substrate-clear) pulse |
| gate_en | output | 1 | Sensor-gate pulses allowed |
| sync_en | output | 1 | Vertical/horizontal sync outputs allowed |

## Verification
The hardest situations to reach are those where staging and timing overlap. One is a write that lands while a train is running. Another is a train that runs past the field strobe. A third is a long exposure whose counter reloads and steps while the sync-off and fine-window settings wait for a field strobe. Directed fields place a mid-train write, an over-long count and a multi-field exposure. Random fields then vary the gate-line position, field length and register values. A cycle-level reference model in the bench checks every output on every clock.

// File: rtl/shut_pkg.sv
// Shared register addresses for the shutter controller.
package shut_pkg;
    typedef enum logic [2:0] {
        A_POL  = 3'd0,
        A_T1A  = 3'd1,
        A_T1B  = 3'd2,
        A_CNT  = 3'd3,
        A_T2A  = 3'd4,
        A_T2B  = 3'd5,
        A_EXP  = 3'd6,
        A_SOFF = 3'd7
    } shut_addr_e;
endpackage

// File: rtl/shut_regs.sv
// Register file: staging copies written by software, plus live copies.
// Line group (polarity, first window) goes live on ld_line.
// Field group (second window, sync-off) goes live on ld_field.
// Assumes ld_line and ld_field never both pulse in one cycle.
module shut_regs
    import shut_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [PW-1:0] wr_data,
    input  logic          ld_line,
    input  logic          ld_field,
    output logic          pol_a,
    output logic [PW-1:0] t1a_a,
    output logic [PW-1:0] t1b_a,
    output logic [PW-1:0] cnt_s,
    output logic [PW-1:0] t2a_a,
    output logic [PW-1:0] t2b_a,
    output logic [PW-1:0] exp_s,
    output logic          soff_a
);
    localparam logic [PW-1:0] ALL1 = {PW{1'b1}};

    logic          pol_s, soff_s;
    logic [PW-1:0] t1a_s, t1b_s, t2a_s, t2b_s;

    // Staging registers, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_s  <= 1'b0;
            t1a_s  <= '0;
            t1b_s  <= '0;
            cnt_s  <= '0;
            t2a_s  <= ALL1;
            t2b_s  <= ALL1;
            exp_s  <= '0;
            soff_s <= 1'b0;
        end else if (wr_en) begin
            case (shut_addr_e'(wr_addr))
                A_POL:  pol_s  <= wr_data[0];
                A_T1A:  t1a_s  <= wr_data;
                A_T1B:  t1b_s  <= wr_data;
                A_CNT:  cnt_s  <= wr_data;
                A_T2A:  t2a_s  <= wr_data;
                A_T2B:  t2b_s  <= wr_data;
                A_EXP:  exp_s  <= wr_data;
                A_SOFF: soff_s <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Line group goes live when the gate line closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_a <= 1'b0;
            t1a_a <= '0;
            t1b_a <= '0;
        end else if (ld_line) begin
            pol_a <= pol_s;
            t1a_a <= t1a_s;
            t1b_a <= t1b_s;
        end
    end

    // Field group goes live at the field strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t2a_a  <= ALL1;
            t2b_a  <= ALL1;
            soff_a <= 1'b0;
        end else if (ld_field) begin
            t2a_a  <= t2a_s;
            t2b_a  <= t2b_s;
            soff_a <= soff_s;
        end
    end
endmodule

// File: rtl/shut_train.sv
// Per-line pulse train: counts the remaining pulse lines and forms the
// registered shutter output from the pixel windows.
// Assumes at most one line strobe per line and pix in range.
module shut_train #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix,
    input  logic          line_stb,
    input  logic          field_stb,
    input  logic          ld_line,
    input  logic          susp,
    input  logic          pol,
    input  logic [PW-1:0] t1a,
    input  logic [PW-1:0] t1b,
    input  logic [PW-1:0] cnt_new,
    input  logic [PW-1:0] t2a,
    input  logic [PW-1:0] t2b,
    output logic [PW-1:0] remain,
    output logic          hp_en,
    output logic          sub_out
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic active, last, in_w1, in_w2, pulse;

    always_comb begin
        active = (remain != '0);
        last   = (remain == ONE);
        hp_en  = !((&t2a) && (&t2b));
        in_w1  = (pix >= t1a) && (pix < t1b);
        in_w2  = (pix >= t2a) && (pix < t2b);
        pulse  = active && !susp && (in_w1 || (last && hp_en && in_w2));
    end

    // Remaining-lines counter: a field strobe clears it, a gate line loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (field_stb)
            remain <= '0;
        else if (ld_line)
            remain <= cnt_new;
        else if (line_stb && active)
            remain <= remain - ONE;
    end

    // Registered shutter output with polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_out <= 1'b0;
        else
            sub_out <= pol ^ pulse;
    end
endmodule

// File: rtl/shut_expo.sv
// Long-exposure field counter: holds off shutter, gate and (optionally)
// sync while nonzero. Reloads from the exposure value when it is zero.
module shut_expo #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_stb,
    input  logic [PW-1:0] exp_val,
    input  logic          soff,
    output logic [PW-1:0] exp_cnt,
    output logic          susp,
    output logic          gate_en,
    output logic          sync_en
);
    // Field counter: reload at zero, else step down on each field strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_cnt <= '0;
        else if (field_stb) begin
            if (exp_cnt == '0)
                exp_cnt <= exp_val;
            else
                exp_cnt <= exp_cnt - PW'(1);
        end
    end

    // Suppression flags for the shutter, gate and sync outputs.
    always_comb begin
        susp    = (exp_cnt != '0);
        gate_en = !susp;
        sync_en = !(susp && soff);
    end
endmodule

// File: rtl/shut_ctrl.sv
// Top: CCD electronic shutter pulse controller.
// Assumes the strobes are single-cycle pulses. field_stb normally
// coincides with the last line_stb of a field.
module shut_ctrl #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix,
    input  logic          line_stb,
    input  logic          field_stb,
    input  logic          gate_line,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [PW-1:0] wr_data,
    output logic          sub_out,
    output logic          gate_en,
    output logic          sync_en
);
    logic          ld_line;
    logic          pol_a, soff_a, susp, hp_en;
    logic [PW-1:0] t1a_a, t1b_a, cnt_s, t2a_a, t2b_a, exp_s, remain, exp_cnt;

    // Train load event: end of the gate line, unless a field strobe overrides it.
    assign ld_line = line_stb && gate_line && !field_stb;

    shut_regs #(.PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ld_line(ld_line), .ld_field(field_stb),
        .pol_a(pol_a), .t1a_a(t1a_a), .t1b_a(t1b_a), .cnt_s(cnt_s),
        .t2a_a(t2a_a), .t2b_a(t2b_a), .exp_s(exp_s), .soff_a(soff_a)
    );

    shut_train #(.PW(PW)) u_train (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line_stb(line_stb),
        .field_stb(field_stb), .ld_line(ld_line), .susp(susp),
        .pol(pol_a), .t1a(t1a_a), .t1b(t1b_a), .cnt_new(cnt_s),
        .t2a(t2a_a), .t2b(t2b_a), .remain(remain), .hp_en(hp_en),
        .sub_out(sub_out)
    );

    shut_expo #(.PW(PW)) u_expo (
        .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .exp_val(exp_s),
        .soff(soff_a), .exp_cnt(exp_cnt), .susp(susp), .gate_en(gate_en),
        .sync_en(sync_en)
    );
endmodule

// File: rtl/shut_ctrl_chk.sv
// Checker for shut_ctrl: temporal properties on ports and internal state.
module shut_ctrl_chk #(
    parameter int PW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_stb,
    input logic          field_stb,
    input logic          gate_line,
    input logic          sub_out,
    input logic          gate_en,
    input logic          sync_en,
    input logic          pol_a,
    input logic          hp_en,
    input logic [PW-1:0] remain,
    input logic [PW-1:0] exp_cnt
);
    // R7: while suppressed, the shutter sits at its idle level next cycle.
    p_idle_when_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> sub_out == $past(pol_a));

    // R4: with no lines remaining, no pulse appears.
    p_no_pulse_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0) |=> sub_out == $past(pol_a));

    // R9: sync is only dropped during a long exposure.
    p_sync_needs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !gate_en);

    // R1: the line count never grows except at a gate-line end.
    p_remain_no_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_stb && gate_line) |=> remain <= $past(remain));

    // R11: a field strobe empties the train.
    p_field_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        field_stb |=> remain == '0);

    // R7: the field counter steps down by one on a field strobe.
    p_exp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_stb && exp_cnt != '0) |=> exp_cnt == $past(exp_cnt) - PW'(1));

    // R7: the field counter only moves on a field strobe.
    p_exp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(exp_cnt));

    // R6: the second window is off straight out of reset.
    p_hp_off_at_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hp_en);
endmodule

bind shut_ctrl shut_ctrl_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
    .gate_line(gate_line), .sub_out(sub_out), .gate_en(gate_en),
    .sync_en(sync_en), .pol_a(pol_a), .hp_en(hp_en), .remain(remain),
    .exp_cnt(exp_cnt)
);

// File: tb/shut_ctrl_bench.sv
module shut_ctrl_bench;
    localparam int PW   = 12;
    localparam int LLEN = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pix = '0;
    logic          line_stb = 1'b0, field_stb = 1'b0, gate_line = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [PW-1:0] wr_data = '0;
    logic          sub_out, gate_en, sync_en;

    shut_ctrl #(.PW(PW)) u_shut_ctrl (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line_stb(line_stb),
        .field_stb(field_stb), .gate_line(gate_line), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sub_out(sub_out),
        .gate_en(gate_en), .sync_en(sync_en)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    total = 0, bad = 0, cycles = 0;
    bit    done = 0;
    string tag = "R10";

    // Reference model state, mirroring the state just after each edge.
    bit            s_pol, s_soff, a_pol, a_soff;
    logic [PW-1:0] s_t1a, s_t1b, s_cnt, s_t2a, s_t2b, s_exp;
    logic [PW-1:0] a_t1a, a_t1b, a_t2a, a_t2b, m_rem, m_exp;
    bit            e_sub;

    function automatic bit win(input logic [PW-1:0] p, input logic [PW-1:0] lo,
                               input logic [PW-1:0] hi);
        return (p >= lo) && (p < hi);
    endfunction

    // Expected shutter level for given pixel and model state (R2, R5, R6, R7).
    function automatic bit exp_level(input logic [PW-1:0] p);
        bit hp, pl;
        hp = !((a_t2a == '1) && (a_t2b == '1));
        pl = (m_rem != 0) && (m_exp == 0) &&
             (win(p, a_t1a, a_t1b) || (m_rem == 1 && hp && win(p, a_t2a, a_t2b)));
        return a_pol ^ pl;
    endfunction

    task automatic chk(input bit got, input bit expv, input string t, input string what);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s %s got=%b exp=%b at cycle %0d", t, what, got, expv, cycles);
        end
    endtask

    task automatic model_reset();
        s_pol = 0; s_soff = 0; a_pol = 0; a_soff = 0;
        s_t1a = 0; s_t1b = 0; s_cnt = 0; s_exp = 0;
        s_t2a = '1; s_t2b = '1; a_t2a = '1; a_t2b = '1;
        a_t1a = 0; a_t1b = 0; m_rem = 0; m_exp = 0; e_sub = 0;
    endtask

    // One clock: check outputs, drive inputs, advance the model.
    task automatic cyc(input logic [PW-1:0] p, input bit ls, input bit fs, input bit gl,
                       input bit we, input logic [2:0] wa, input logic [PW-1:0] wd);
        bit ld;
        @(negedge clk);
        chk(sub_out, e_sub, tag, "sub_out");
        chk(gate_en, m_exp == 0, "R8", "gate_en");
        chk(sync_en, !(m_exp != 0 && a_soff), "R9", "sync_en");
        pix = p; line_stb = ls; field_stb = fs; gate_line = gl;
        wr_en = we; wr_addr = wa; wr_data = wd;
        e_sub = exp_level(p);
        ld = ls && gl && !fs;
        if (fs) m_rem = 0;
        else if (ld) m_rem = s_cnt;
        else if (ls && m_rem != 0) m_rem = m_rem - 1;
        if (ld) begin a_pol = s_pol; a_t1a = s_t1a; a_t1b = s_t1b; end
        if (fs) begin
            a_t2a = s_t2a; a_t2b = s_t2b; a_soff = s_soff;
            if (m_exp == 0) m_exp = s_exp; else m_exp = m_exp - 1;
        end
        if (we) case (wa)
            3'd0: s_pol = wd[0];
            3'd1: s_t1a = wd;
            3'd2: s_t1b = wd;
            3'd3: s_cnt = wd;
            3'd4: s_t2a = wd;
            3'd5: s_t2b = wd;
            3'd6: s_exp = wd;
            default: s_soff = wd[0];
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [PW-1:0] d);
        cyc('0, 0, 0, 0, 1, a, d);
    endtask

    // A field of nl lines, gate at gl; optional write at the start of line wl.
    task automatic run_field(input int nl, input int gl, input int wl,
                             input logic [2:0] wa, input logic [PW-1:0] wd);
        for (int l = 0; l < nl; l++)
            for (int p = 0; p < LLEN; p++)
                cyc(PW'(p), p == LLEN-1, (p == LLEN-1) && (l == nl-1), l == gl,
                    (l == wl) && (p == 0), wa, wd);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R10";
        chk(sub_out, 0, "R10", "sub_out reset");
        chk(gate_en, 1, "R10", "gate_en reset");
        chk(sync_en, 1, "R10", "sync_en reset");
        rst_n = 1;

        tag = "R4";   // count 0: no pulses, default second window off (R6)
        run_field(6, 1, -1, 0, 0);
        tag = "R1";
        wr(3'd1, 5); wr(3'd2, 9); wr(3'd3, 3);
        run_field(7, 1, -1, 0, 0);
        run_field(8, 3, -1, 0, 0);
        tag = "R2";
        wr(3'd0, 1); wr(3'd1, 20); wr(3'd2, 30);
        run_field(6, 0, -1, 0, 0);
        tag = "R3";   // mid-train write must not touch the running train
        run_field(8, 1, 3, 3'd3, 1);
        run_field(8, 1, 3, 3'd1, 0);
        tag = "R5";
        wr(3'd4, 25); wr(3'd5, 35); wr(3'd3, 2);
        run_field(5, 1, -1, 0, 0);
        run_field(6, 1, -1, 0, 0);
        tag = "R6";
        wr(3'd4, 12'hFFF);
        run_field(6, 1, -1, 0, 0);
        wr(3'd5, 12'hFFF);
        run_field(6, 1, -1, 0, 0);
        run_field(6, 1, -1, 0, 0);
        tag = "R11";  // train longer than the field; gate on the last line
        wr(3'd3, 10);
        run_field(5, 1, -1, 0, 0);
        run_field(4, 3, -1, 0, 0);
        tag = "R7";
        wr(3'd6, 2); wr(3'd7, 1); wr(3'd3, 3);
        for (int f = 0; f < 6; f++) run_field(5, 1, -1, 0, 0);
        tag = "R9";
        wr(3'd7, 0);
        for (int f = 0; f < 4; f++) run_field(5, 1, -1, 0, 0);
        wr(3'd6, 0);
        for (int f = 0; f < 4; f++) run_field(5, 1, -1, 0, 0);

        tag = "R1 R2 R5 R7";
        void'($urandom(32'd1234));
        for (int f = 0; f < 120; f++) begin
            if ($urandom_range(0, 2) == 0) wr(3'($urandom_range(0, 5)), PW'($urandom_range(0, LLEN)));
            if ($urandom_range(0, 5) == 0) wr(3'd3, PW'($urandom_range(0, 6)));
            if ($urandom_range(0, 7) == 0) wr(3'd6, PW'($urandom_range(0, 2)));
            if ($urandom_range(0, 5) == 0) wr(3'd7, PW'($urandom_range(0, 1)));
            run_field($urandom_range(3, 8), $urandom_range(0, 3), $urandom_range(0, 9),
                      3'($urandom_range(0, 3)), PW'($urandom_range(0, LLEN)));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule